// File: doc/BRIEF.md
# Sprite XOR Blitter with Collision Detect

This block draws a bitmap sprite, one to fifteen rows tall and eight pixels wide, into a monochrome 64 by 32 framebuffer that it owns. A draw command carries a screen position, a row count and a base address in sprite memory. The block fetches one sprite byte per row through a synchronous read port. It then merges that byte into the matching framebuffer row by exclusive-or. When the command completes, it reports whether any lit pixel was switched off.

A second command blanks the whole framebuffer. A separate registered pixel port lets a display scan-out engine read any pixel at any time, independently of drawing. Software-visible sequencing is left to the surrounding controller. It issues a command while the block is idle, then waits for the one-cycle completion pulse.

Top module: `sprite_blitter`

## Requirements
- R1: For a draw with height n and base address B, the block issues exactly n memory reads, one per sprite row, at addresses B, B+1, ... B+n-1 taken modulo 4096 and in that order. Read data is expected one clock after `mem_rd`.
- R2: Sprite row r is placed on screen row Y+r. Byte bit 7 lands on column X, and each lower bit lands one column further right, so bit 0 lands on column X+7.
- R3: Each set sprite bit toggles the existing framebuffer pixel. A clear sprite bit leaves its pixel unchanged. Drawing the same sprite twice therefore restores the previous image.
- R4: `collision` is forced to 0 on the clock edge that accepts a command. When `done` pulses, it is 1 if that draw turned at least one lit pixel off, and 0 otherwise.
- R5: Columns are taken modulo 64: an X of 64 or more wraps, and sprite pixels past column 63 continue at column 0.
- R6: Rows are taken modulo 32: a Y of 32 or more wraps, and sprite rows past row 31 continue at row 0.
- R7: `scan_pixel` shows, one clock after `scan_addr` is applied, the pixel at row `scan_addr[10:6]` and column `scan_addr[5:0]`.
- R8: A clear command sets all 2048 pixels to 0, pulses `done` with `collision` 0, and wins over a draw command given in the same cycle.
- R9: `busy` rises the cycle after a command with nonzero work is accepted. It stays high until the cycle `done` pulses, in which `busy` is low. Commands presented while `busy` is high are ignored.
- R10: A draw with height 0 issues no read, changes no pixel, and pulses `done` with `collision` 0 on the cycle after it is accepted.
- R11: After reset, `busy`, `done` and `collision` are 0 and every pixel is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| draw_start | input | 1 | Accept a draw command while idle |
| clear_start | input | 1 | Accept a clear command while idle |
| pos_x | input | 8 | Sprite left column, taken modulo 64 |
| pos_y | input | 8 | Sprite top row, taken modulo 32 |
| height | input | 4 | Sprite rows, 0 to 15 |
| base_addr | input | 12 | Memory address of sprite row 0 |
| mem_rd | output | 1 | Sprite memory read strobe |
| mem_addr | output | 12 | Sprite memory read address |
| mem_data | input | 8 | Sprite byte, valid one clock after the read strobe |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| collision | output | 1 | Lit pixel was erased by the last draw |
| scan_addr | input | 11 | Scan-out pixel address, row times 64 plus column |
| scan_pixel | output | 1 | Scan-out pixel value, one clock latency |

## Verification
The bench places sprites across the right edge, across the bottom edge and at coordinates beyond the screen range. A design that clipped there, or used the wrong modulo, would leave pixels missing or misplaced in the full-screen comparison. It redraws a sprite onto itself to catch an overwrite in place of a toggle, which would leave the image set and report no collision. It also draws onto unlit areas next to lit ones, so a detector that flags any overlap, rather than only lit-to-unlit changes, would give a false collision. Further cases cover a zero height, where a faulty design would read memory or hang; a command arriving mid-draw, which a faulty design would accept and so produce an extra `done`; a sprite base address that wraps at the top of memory; and a clear that must blank every row and clear a stale collision flag.

// File: rtl/sprite_pkg.sv
package sprite_pkg;

    localparam int FB_W    = 64;
    localparam int FB_H    = 32;
    localparam int COL_W   = $clog2(FB_W);
    localparam int ROW_W   = $clog2(FB_H);
    localparam int PIX_AW  = COL_W + ROW_W;
    localparam int MEM_AW  = 12;
    localparam int SPR_W   = 8;
    localparam int N_W     = 4;
    localparam int COORD_W = 8;
    localparam int CNT_W   = (N_W > ROW_W) ? N_W : ROW_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_WRITE,
        ST_CLEAR
    } blit_state_e;

    // Row update request from the controller to the framebuffer
    typedef struct packed {
        logic             en;
        logic             zero;
        logic [ROW_W-1:0] row;
    } row_req_t;

    // Spread one sprite byte over a screen row: MSB at column x, wrapping at the edge
    function automatic logic [FB_W-1:0] spread_row(input logic [SPR_W-1:0] b,
                                                   input logic [COL_W-1:0] x);
        logic [FB_W-1:0]  m;
        logic [COL_W-1:0] col;
        m = '0;
        for (int i = 0; i < SPR_W; i++) begin
            col = x + COL_W'(i);
            m[col] = b[SPR_W-1-i];
        end
        return m;
    endfunction

endpackage

// File: rtl/sprite_fb.sv
module sprite_fb
    import sprite_pkg::*;
#(
    parameter int W = FB_W,
    parameter int H = FB_H,
    localparam int CW = $clog2(W),
    localparam int RW = $clog2(H)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_row,
    input  logic [W-1:0]  wr_data,
    input  logic [RW-1:0] rd_row,
    output logic [W-1:0]  rd_data,
    input  logic [RW+CW-1:0] scan_addr,
    output logic          scan_pixel
);

    logic [W-1:0] rows [H];

    for (genvar g = 0; g < H; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                rows[g] <= '0;
            end else if (wr_en && (wr_row == RW'(g))) begin
                rows[g] <= wr_data;
            end
        end
    end

    assign rd_data = rows[rd_row];

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_pixel <= 1'b0;
        end else begin
            scan_pixel <= rows[scan_addr[RW+CW-1:CW]][scan_addr[CW-1:0]];
        end
    end

endmodule

// File: rtl/sprite_row_merge.sv
module sprite_row_merge
    import sprite_pkg::*;
#(
    parameter int W = FB_W,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0]     old_row,
    input  logic [SPR_W-1:0] sprite,
    input  logic [CW-1:0]    x_off,
    output logic [W-1:0]     new_row,
    output logic             hit
);

    logic [W-1:0] mask;

    always_comb begin
        mask    = spread_row(sprite, x_off);
        new_row = old_row ^ mask;
        hit     = |(old_row & mask);
    end

endmodule

// File: rtl/sprite_blit_ctrl.sv
module sprite_blit_ctrl
    import sprite_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               draw_start,
    input  logic               clear_start,
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    input  logic [N_W-1:0]     height,
    input  logic [MEM_AW-1:0]  base_addr,
    input  logic [SPR_W-1:0]   mem_data,
    input  logic               row_hit,
    output logic               mem_rd,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic               busy,
    output logic               done,
    output logic               collision,
    output row_req_t           req,
    output logic [COL_W-1:0]   x_off,
    output logic [SPR_W-1:0]   sprite
);

    blit_state_e        state;
    logic [CNT_W-1:0]   cnt;
    logic [N_W-1:0]     n_q;
    logic [MEM_AW-1:0]  base_q;
    logic [ROW_W-1:0]   y_q;
    logic               coll_acc;
    logic               last_row;
    logic               last_clear;

    assign last_row   = (cnt == (CNT_W'(n_q) - CNT_W'(1)));
    assign last_clear = (cnt == CNT_W'(FB_H - 1));

    assign busy     = (state != ST_IDLE);
    assign mem_rd   = (state == ST_FETCH);
    assign mem_addr = base_q + MEM_AW'(cnt);

    always_comb begin
        req.en   = (state == ST_WRITE) || (state == ST_CLEAR);
        req.zero = (state == ST_CLEAR);
        req.row  = y_q + ROW_W'(cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            n_q       <= '0;
            base_q    <= '0;
            x_off     <= '0;
            y_q       <= '0;
            sprite    <= '0;
            coll_acc  <= 1'b0;
            done      <= 1'b0;
            collision <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (clear_start) begin
                        y_q       <= '0;
                        collision <= 1'b0;
                        state     <= ST_CLEAR;
                    end else if (draw_start) begin
                        collision <= 1'b0;
                        coll_acc  <= 1'b0;
                        n_q       <= height;
                        base_q    <= base_addr;
                        x_off     <= COL_W'(pos_x % FB_W);
                        y_q       <= ROW_W'(pos_y % FB_H);
                        if (height == '0) begin
                            done <= 1'b1;
                        end else begin
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: state <= ST_WAIT;
                ST_WAIT: begin
                    sprite <= mem_data;
                    state  <= ST_WRITE;
                end
                ST_WRITE: begin
                    coll_acc <= coll_acc | row_hit;
                    if (last_row) begin
                        collision <= coll_acc | row_hit;
                        done      <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        cnt   <= cnt + CNT_W'(1);
                        state <= ST_FETCH;
                    end
                end
                ST_CLEAR: begin
                    if (last_clear) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sprite_blitter.sv
module sprite_blitter
    import sprite_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               draw_start,
    input  logic               clear_start,
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    input  logic [N_W-1:0]     height,
    input  logic [MEM_AW-1:0]  base_addr,
    output logic               mem_rd,
    output logic [MEM_AW-1:0]  mem_addr,
    input  logic [SPR_W-1:0]   mem_data,
    output logic               busy,
    output logic               done,
    output logic               collision,
    input  logic [PIX_AW-1:0]  scan_addr,
    output logic               scan_pixel
);

    row_req_t          req;
    logic [COL_W-1:0]  x_off;
    logic [SPR_W-1:0]  sprite;
    logic [FB_W-1:0]   old_row;
    logic [FB_W-1:0]   new_row;
    logic [FB_W-1:0]   wr_data;
    logic              row_hit;

    sprite_blit_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .draw_start (draw_start),
        .clear_start(clear_start),
        .pos_x      (pos_x),
        .pos_y      (pos_y),
        .height     (height),
        .base_addr  (base_addr),
        .mem_data   (mem_data),
        .row_hit    (row_hit),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .busy       (busy),
        .done       (done),
        .collision  (collision),
        .req        (req),
        .x_off      (x_off),
        .sprite     (sprite)
    );

    sprite_row_merge #(.W(FB_W)) u_merge (
        .old_row(old_row),
        .sprite (sprite),
        .x_off  (x_off),
        .new_row(new_row),
        .hit    (row_hit)
    );

    assign wr_data = req.zero ? '0 : new_row;

    sprite_fb #(.W(FB_W), .H(FB_H)) u_fb (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (req.en),
        .wr_row    (req.row),
        .wr_data   (wr_data),
        .rd_row    (req.row),
        .rd_data   (old_row),
        .scan_addr (scan_addr),
        .scan_pixel(scan_pixel)
    );

endmodule

// File: rtl/sprite_blitter_chk.sv
module sprite_blitter_chk
    import sprite_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           draw_start,
    input logic           clear_start,
    input logic [N_W-1:0] height,
    input logic           mem_rd,
    input logic           busy,
    input logic           done,
    input logic           collision
);

    AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> busy);  // R1

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);  // R9

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (draw_start && !clear_start && !busy && height != '0) |=> busy);  // R9

    AST_ZERO_HEIGHT_DONE: assert property (@(posedge clk) disable iff (rst)
        (draw_start && !clear_start && !busy && height == '0) |=> (done && !collision && !busy));  // R10

    AST_CLEAR_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (clear_start && !busy) |=> (busy && !collision));  // R8

    AST_COLL_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (draw_start && !busy) |=> !collision);  // R4

endmodule

bind sprite_blitter sprite_blitter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .draw_start (draw_start),
    .clear_start(clear_start),
    .height     (height),
    .mem_rd     (mem_rd),
    .busy       (busy),
    .done       (done),
    .collision  (collision)
);

// File: tb/sprite_blitter_test.sv
`timescale 1ns/1ps
module sprite_blitter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        draw_start = 1'b0;
    logic        clear_start = 1'b0;
    logic [7:0]  pos_x = '0;
    logic [7:0]  pos_y = '0;
    logic [3:0]  height = '0;
    logic [11:0] base_addr = '0;
    logic        mem_rd;
    logic [11:0] mem_addr;
    logic [7:0]  mem_data;
    logic        busy, done, collision;
    logic [10:0] scan_addr = '0;
    logic        scan_pixel;

    int checks = 0;
    int failures = 0;

    logic [7:0]  mem [4096];
    logic        model_fb [2048];
    logic [11:0] addr_q [$];
    logic        coll_q [$];

    always #2.5 clk = ~clk;

    sprite_blitter uut (
        .clk(clk), .rst(rst), .draw_start(draw_start), .clear_start(clear_start),
        .pos_x(pos_x), .pos_y(pos_y), .height(height), .base_addr(base_addr),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
        .busy(busy), .done(done), .collision(collision),
        .scan_addr(scan_addr), .scan_pixel(scan_pixel)
    );

    // Synchronous sprite memory: data one clock after the strobe
    logic [7:0] mem_q = '0;
    always @(posedge clk) if (mem_rd) mem_q <= mem[mem_addr];
    assign mem_data = mem_q;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: reads and completions against expected queues
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rd) begin
                if (addr_q.size() == 0) begin
                    check(1'b0, "R1 unexpected read", int'(mem_addr), 0);
                end else begin
                    automatic logic [11:0] e = addr_q.pop_front();
                    check(mem_addr == e, "R1 read address", int'(mem_addr), int'(e));
                end
            end
            if (done) begin
                if (coll_q.size() == 0) begin
                    check(1'b0, "R9 spurious done", 1, 0);
                end else begin
                    automatic logic e = coll_q.pop_front();
                    check(collision == e, "R4 collision at done", int'(collision), int'(e));
                    check(addr_q.size() == 0, "R1 reads per draw", addr_q.size(), 0);
                end
            end
        end
    end

    task automatic wait_idle();
        while (coll_q.size() != 0) @(negedge clk);
        check(!busy, "R9 busy low after done", int'(busy), 0);
    endtask

    // Driver: update the model, queue expectations, pulse the command
    task automatic do_draw(input int x, input int y, input int n, input int base,
                           input bit poke_mid);
        logic c = 1'b0;
        for (int r = 0; r < n; r++) begin
            automatic logic [7:0] b = mem[(base + r) % 4096];
            addr_q.push_back(12'((base + r) % 4096));
            for (int i = 0; i < 8; i++) begin
                if (b[7-i]) begin
                    automatic int p = (((y % 32) + r) % 32) * 64 + (((x % 64) + i) % 64);
                    if (model_fb[p]) c = 1'b1;
                    model_fb[p] = ~model_fb[p];
                end
            end
        end
        coll_q.push_back(c);
        @(negedge clk);
        pos_x = 8'(x); pos_y = 8'(y); height = 4'(n); base_addr = 12'(base);
        draw_start = 1'b1;
        @(negedge clk);
        draw_start = 1'b0;
        if (n > 0) begin
            check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
            check(collision == 1'b0, "R4 cleared at start", int'(collision), 0);
        end else begin
            check(done == 1'b1 && !busy, "R10 zero height done next cycle", int'(done), 1);
            check(collision == 1'b0, "R10 zero height collision", int'(collision), 0);
        end
        if (poke_mid) begin
            @(negedge clk);
            pos_x = 8'd0; pos_y = 8'd0; height = 4'd3; base_addr = 12'h200;
            draw_start = 1'b1; clear_start = 1'b1;
            @(negedge clk);
            draw_start = 1'b0; clear_start = 1'b0;
        end
        wait_idle();
    endtask

    task automatic do_clear(input bit with_draw);
        coll_q.push_back(1'b0);
        for (int p = 0; p < 2048; p++) model_fb[p] = 1'b0;
        @(negedge clk);
        clear_start = 1'b1;
        draw_start  = with_draw;
        height = 4'd2; base_addr = 12'h100;
        @(negedge clk);
        clear_start = 1'b0; draw_start = 1'b0;
        check(busy == 1'b1, "R8 clear busy", int'(busy), 1);
        check(collision == 1'b0, "R8 clear collision", int'(collision), 0);
        wait_idle();
    endtask

    // Full scan through the display port against the model
    task automatic verify_fb(input string tag);
        int bad = 0;
        int first = -1;
        for (int p = 0; p < 2048; p++) begin
            scan_addr = 11'(p);
            @(negedge clk);
            if (scan_pixel !== model_fb[p]) begin
                bad++;
                if (first < 0) first = p;
            end
        end
        check(bad == 0, tag, first, bad == 0 ? 0 : int'(model_fb[first]));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        for (int a = 0; a < 4096; a++) mem[a] = 8'((a * 37 + 11) & 255);
        for (int p = 0; p < 2048; p++) model_fb[p] = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !collision, "R11 reset outputs",
              {busy, done, collision}, 0);
        verify_fb("R11 R7 framebuffer zero after reset");

        // R2: single-pixel and bit-order patterns
        mem[12'h100] = 8'h80; mem[12'h101] = 8'h01; mem[12'h102] = 8'hA5;
        mem[12'h103] = 8'hF0; mem[12'h104] = 8'h3C;
        do_draw(10, 5, 5, 12'h100, 1'b0);
        verify_fb("R2 R7 bit order and row placement");

        // R3, R4: redraw erases and collides
        do_draw(10, 5, 5, 12'h100, 1'b0);
        verify_fb("R3 redraw restores blank screen");

        // R4: adjacent draws onto unlit pixels give no collision
        mem[12'h110] = 8'hF0;
        do_draw(0, 0, 1, 12'h110, 1'b0);
        mem[12'h111] = 8'h0F;
        do_draw(0, 0, 1, 12'h111, 1'b0);
        verify_fb("R3 merge with existing pixels");
        // partial overlap erases one lit pixel
        mem[12'h112] = 8'h01;
        do_draw(0, 0, 1, 12'h112, 1'b0);

        // R5: right-edge wrap and out-of-range X
        do_draw(60, 10, 3, 12'h300, 1'b0);
        do_draw(70, 12, 2, 12'h320, 1'b0);
        verify_fb("R5 column wrap");

        // R6: bottom-edge wrap, out-of-range Y, memory address wrap (R1)
        do_draw(20, 30, 4, 12'hFFE, 1'b0);
        do_draw(30, 40, 3, 12'h340, 1'b0);
        verify_fb("R6 row wrap");

        // R10: zero height touches nothing
        do_draw(5, 5, 0, 12'h400, 1'b0);
        verify_fb("R10 zero height leaves screen");

        // R9: commands during a draw are ignored
        do_draw(33, 7, 6, 12'h500, 1'b1);
        verify_fb("R9 mid-draw command ignored");

        // R4: collision case then clear resets it (R8, clear wins over draw)
        do_draw(33, 7, 6, 12'h500, 1'b0);
        do_draw(1, 1, 15, 12'h600, 1'b0);
        do_draw(1, 1, 15, 12'h600, 1'b0);
        do_draw(50, 20, 15, 12'h700, 1'b0);
        do_clear(1'b1);
        verify_fb("R8 clear blanks screen");

        // Full-height draw after clear
        do_draw(63, 31, 15, 12'h800, 1'b0);
        verify_fb("R5 R6 max height corner wrap");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule